// File: doc/BRIEF.md
# Floating-Point Control and Status Register File

This block keeps the 32-bit control and status word of a floating-point unit and lets a 64-bit general-purpose datapath reach it through four numbered views. View 0 covers the whole word. View 1 covers the exception enables, view 2 covers the cause and sticky flag fields, and view 3 covers the rounding-mode field. A write through view 0 overwrites the word. A write through any other view changes only the bits that view covers. A read returns the word masked by the chosen view and sign-extended to 64 bits.

The block also drives the rounding mode to the arithmetic datapath. It sends both the raw 2-bit field and a translated 3-bit datapath code. It pulses an update strobe for one cycle when a write could have changed the mode. Writes arrive on a valid/ready channel. The block takes one write per cycle, so `wr_ready` is always high and the channel never applies back-pressure. A write is accepted on any rising edge where `wr_valid` is high. Reads are combinational on the read index and need no handshake.

Top module: `fcsr_regfile`

## Requirements
- R1: After reset the word is zero. Every view reads zero, `rm_code` is 3'b000 and `rm_update` is low.
- R2: An accepted write through view 0 replaces all 32 bits of the word with `wr_data[31:0]`. `wr_data[63:32]` has no effect.
- R3: An accepted write through view 1, 2 or 3 gives new = (old & ~M) | (wr_data[31:0] & M). M is 32'h0000_001F for view 1, 32'h1F1F_0000 for view 2 and 32'h0000_0300 for view 3.
- R4: `rd_data` equals the word ANDed with the mask of view `rd_view`, with bit 31 of that result copied into bits 63:32. The mask of view 0 is all ones.
- R5: A write index of 4 to 31 leaves the word unchanged. A read index of 4 to 31 returns zero.
- R6: `rm_update` is high for exactly the one cycle after an accepted write through view 0 or view 3. It stays low after writes through views 1, 2 or illegal indices.
- R7: `rm_code` translates word bits [9:8] as follows: 0 gives 3'b000 (nearest-even), 1 gives 3'b011 (toward zero), 2 gives 3'b010 (toward +inf) and 3 gives 3'b001 (toward -inf). It changes only in cycles where `rm_update` is high.
- R8: `wr_ready` is always high. The effect of a write is visible on `rd_data`, `rm_field` and `rm_code` in the cycle after the accepting edge.
- R9: `rm_field` always equals word bits [9:8].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write accepted (always high) |
| wr_view | input | 5 | Write view index |
| wr_data | input | 64 | Write source value |
| rd_view | input | 5 | Read view index |
| rd_data | output | 64 | Masked, sign-extended read value |
| rm_field | output | 2 | Raw rounding-mode field |
| rm_code | output | 3 | Datapath rounding-mode code |
| rm_update | output | 1 | One-cycle mode update strobe |

## Verification
A corrupted word shows on `rd_data` through view 0 one cycle after the faulty write. A merge that touches bits outside a view's mask therefore appears at the next full read. A wrong rounding-mode path shows in two ways: `rm_code` can disagree with `rm_field`, or `rm_code` can move without the strobe. A strobe raised by a view 1 or 2 write is visible at the ports in the very next cycle. Reads through view 0 with bit 31 set expose a broken sign extension at once.

// File: rtl/fcsr_pkg.sv
package fcsr_pkg;
  localparam int CSR_W    = 32;
  localparam int RM_LSB   = 8;
  localparam int RM_W     = 2;
  localparam int RMC_W    = 3;
  localparam int VIEW_CNT = 4;

  typedef logic [CSR_W-1:0] csr_word_t;

  localparam csr_word_t MASK_FULL   = 32'hFFFF_FFFF;
  localparam csr_word_t MASK_ENABLE = 32'h0000_001F;
  localparam csr_word_t MASK_FLAGS  = 32'h1F1F_0000;
  localparam csr_word_t MASK_RMODE  = 32'h0000_0300;

  typedef enum logic [RMC_W-1:0] {
    RMC_NEAR_EVEN = 3'b000,
    RMC_DOWN      = 3'b001,
    RMC_UP        = 3'b010,
    RMC_ZERO      = 3'b011
  } rm_code_e;

  function automatic csr_word_t view_mask(input int unsigned idx);
    case (idx)
      0:       return MASK_FULL;
      1:       return MASK_ENABLE;
      2:       return MASK_FLAGS;
      3:       return MASK_RMODE;
      default: return '0;
    endcase
  endfunction

  function automatic rm_code_e map_rm(input logic [RM_W-1:0] fld);
    case (fld)
      2'd0:    return RMC_NEAR_EVEN;
      2'd1:    return RMC_ZERO;
      2'd2:    return RMC_UP;
      default: return RMC_DOWN;
    endcase
  endfunction
endpackage

// File: rtl/fcsr_view_decode.sv
module fcsr_view_decode
  import fcsr_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic [IDX_W-1:0] idx,
  output csr_word_t        mask,
  output logic             legal,
  output logic             touches_rm
);
  localparam int LEGAL_MAX = VIEW_CNT - 1;

  csr_word_t table_q [VIEW_CNT];

  for (genvar v = 0; v < VIEW_CNT; v++) begin : g_tab
    assign table_q[v] = view_mask(v);
  end

  always_comb begin
    legal      = (int'(idx) <= LEGAL_MAX);
    mask       = '0;
    for (int v = 0; v < VIEW_CNT; v++) begin
      if (int'(idx) == v) mask = table_q[v];
    end
    touches_rm = legal && ((mask & MASK_RMODE) != '0);
  end
endmodule

// File: rtl/fcsr_merge.sv
module fcsr_merge
  import fcsr_pkg::*;
(
  input  csr_word_t old_word,
  input  csr_word_t src_word,
  input  csr_word_t mask,
  output csr_word_t new_word
);
  always_comb new_word = (old_word & ~mask) | (src_word & mask);
endmodule

// File: rtl/fcsr_rm_stage.sv
module fcsr_rm_stage
  import fcsr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [RM_W-1:0]  next_field,
  output logic [RMC_W-1:0] code,
  output logic             strobe
);
  rm_code_e code_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q <= RMC_NEAR_EVEN;
      strobe <= 1'b0;
    end else begin
      strobe <= push;
      if (push) code_q <= map_rm(next_field);
    end
  end

  assign code = code_q;
endmodule

// File: rtl/fcsr_regfile.sv
module fcsr_regfile
  import fcsr_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [IDX_W-1:0]  wr_view,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_view,
  output logic [DATA_W-1:0] rd_data,
  output logic [RM_W-1:0]   rm_field,
  output logic [RMC_W-1:0]  rm_code,
  output logic              rm_update
);
  localparam int EXT_W = DATA_W - CSR_W;

  csr_word_t csr_q, csr_next, wr_mask, rd_mask, rd_word;
  logic      wr_legal, wr_rm, rd_legal, rd_rm, wr_fire;
  logic      unused_bits;

  assign wr_ready    = 1'b1;
  assign wr_fire     = wr_valid && wr_ready && wr_legal;
  assign unused_bits = ^{wr_data[DATA_W-1:CSR_W], rd_legal, rd_rm};

  fcsr_view_decode #(.IDX_W(IDX_W)) u_wr_dec (
    .idx(wr_view), .mask(wr_mask), .legal(wr_legal), .touches_rm(wr_rm)
  );

  fcsr_view_decode #(.IDX_W(IDX_W)) u_rd_dec (
    .idx(rd_view), .mask(rd_mask), .legal(rd_legal), .touches_rm(rd_rm)
  );

  fcsr_merge u_merge (
    .old_word(csr_q), .src_word(wr_data[CSR_W-1:0]),
    .mask(wr_mask), .new_word(csr_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       csr_q <= '0;
    else if (wr_fire) csr_q <= csr_next;
  end

  fcsr_rm_stage u_rm (
    .clk(clk), .rst_n(rst_n), .push(wr_fire && wr_rm),
    .next_field(csr_next[RM_LSB +: RM_W]),
    .code(rm_code), .strobe(rm_update)
  );

  assign rd_word  = csr_q & rd_mask;
  assign rd_data  = {{EXT_W{rd_word[CSR_W-1]}}, rd_word};
  assign rm_field = csr_q[RM_LSB +: RM_W];
endmodule

// File: rtl/fcsr_regfile_chk.sv
module fcsr_regfile_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_valid,
  input logic [4:0]  wr_view,
  input logic [4:0]  rd_view,
  input logic [63:0] rd_data,
  input logic [1:0]  rm_field,
  input logic [2:0]  rm_code,
  input logic        rm_update,
  input logic [31:0] csr_q
);
  logic past_ok;
  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  p_strobe_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && rm_update) |-> $past(wr_valid && (wr_view == 5'd0 || wr_view == 5'd3)));

  p_strobe_fire_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_view == 5'd3) |=> rm_update);

  p_code_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !rm_update) |-> $stable(rm_code));

  p_illegal_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_view > 5'd3) |-> (rd_data == 64'd0));

  p_illegal_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_view > 5'd3) |=> $stable(csr_q));

  p_enable_merge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_view == 5'd1) |=> (csr_q[31:5] == $past(csr_q[31:5])));

  p_sign_ext_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[63:32] == {32{rd_data[31]}});

  p_field_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rm_field == csr_q[9:8]);
endmodule

bind fcsr_regfile fcsr_regfile_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_view(wr_view),
  .rd_view(rd_view), .rd_data(rd_data), .rm_field(rm_field),
  .rm_code(rm_code), .rm_update(rm_update), .csr_q(csr_q)
);

// File: tb/tb_fcsr_regfile.sv
module tb_fcsr_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [4:0]  wr_view = '0;
  logic [63:0] wr_data = '0;
  logic [4:0]  rd_view = '0;
  logic [63:0] rd_data;
  logic [1:0]  rm_field;
  logic [2:0]  rm_code;
  logic        rm_update;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  fcsr_regfile dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_view(wr_view), .wr_data(wr_data), .rd_view(rd_view),
    .rd_data(rd_data), .rm_field(rm_field), .rm_code(rm_code),
    .rm_update(rm_update)
  );

  typedef struct packed {
    logic [4:0]  view;
    logic [63:0] data;
    logic [31:0] word;
    logic        upd;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{5'd0,  64'hFFFF_FFFF_1234_5678, 32'h1234_5678, 1'b1},
    '{5'd1,  64'h0000_0000_FFFF_FFFF, 32'h1234_567F, 1'b0},
    '{5'd2,  64'h0000_0000_0000_0000, 32'h0020_567F, 1'b0},
    '{5'd3,  64'h0000_0000_0000_0100, 32'h0020_557F, 1'b1},
    '{5'd7,  64'h0000_0000_FFFF_FFFF, 32'h0020_557F, 1'b0},
    '{5'd3,  64'h0000_0000_FFFF_FFFF, 32'h0020_577F, 1'b1},
    '{5'd2,  64'h0000_0000_FFFF_FFFF, 32'h1F3F_577F, 1'b0},
    '{5'd0,  64'h0000_0000_8000_0000, 32'h8000_0000, 1'b1},
    '{5'd1,  64'h0000_0000_0000_0015, 32'h8000_0015, 1'b0},
    '{5'd31, 64'h0000_0000_0000_0000, 32'h8000_0015, 1'b0}
  };

  function automatic logic [2:0] exp_code(input logic [1:0] f);
    case (f)
      2'd0: return 3'b000;
      2'd1: return 3'b011;
      2'd2: return 3'b010;
      default: return 3'b001;
    endcase
  endfunction

  function automatic logic [63:0] sext(input logic [31:0] w);
    return {{32{w[31]}}, w};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [4:0] v, input logic [63:0] d);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_view  = v;
    wr_data  = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic read_chk(input logic [4:0] v, input logic [63:0] exp, input string req);
    rd_view = v;
    #0.5;
    check(req, rd_data, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int v = 0; v < 4; v++) read_chk(5'(v), 64'd0, "R1 reset read");
    check("R1 reset rm_code", 64'(rm_code), 64'd0);
    check("R1 reset rm_update", 64'(rm_update), 64'd0);
    check("R8 wr_ready", 64'(wr_ready), 64'd1);

    // R2 R3 R5 R6 R7 R9: vector walk
    for (int i = 0; i < NV; i++) begin
      rd_view = 5'd0;
      do_write(VEC[i].view, VEC[i].data);
      #0.5;
      check("R2/R3/R5 word via view 0", rd_data, sext(VEC[i].word));
      check("R6 rm_update", 64'(rm_update), 64'(VEC[i].upd));
      check("R7 rm_code", 64'(rm_code), 64'(exp_code(VEC[i].word[9:8])));
      check("R9 rm_field", 64'(rm_field), 64'(VEC[i].word[9:8]));
    end

    // R6: strobe lasts one cycle
    do_write(5'd0, 64'h0000_0000_1F3F_577F);
    check("R6 strobe high", 64'(rm_update), 64'd1);
    @(negedge clk);
    check("R6 strobe one cycle", 64'(rm_update), 64'd0);

    // R4: masked reads
    read_chk(5'd1, 64'h0000_0000_0000_001F, "R4 view1 read");
    read_chk(5'd2, 64'h0000_0000_1F1F_0000, "R4 view2 read");
    read_chk(5'd3, 64'h0000_0000_0000_0300, "R4 view3 read");
    read_chk(5'd5, 64'd0, "R5 illegal read");
    read_chk(5'd31, 64'd0, "R5 illegal read 31");

    // R4: sign extension through view 0
    do_write(5'd0, 64'h0000_0000_8000_0100);
    read_chk(5'd0, 64'hFFFF_FFFF_8000_0100, "R4 sign extension");
    read_chk(5'd3, 64'h0000_0000_0000_0100, "R4 view3 no sign");
    check("R7 code after full write", 64'(rm_code), 64'(3'b011));

    // R8: write visible exactly one cycle after acceptance
    rd_view = 5'd3;
    @(negedge clk);
    wr_valid = 1'b1; wr_view = 5'd3; wr_data = 64'h200;
    #0.5;
    check("R8 not yet visible", rd_data, 64'h100);
    @(negedge clk);
    wr_valid = 1'b0;
    #0.5;
    check("R8 visible next cycle", rd_data, 64'h200);
    check("R7 code toward +inf", 64'(rm_code), 64'(3'b010));

    // R1: reset clears again
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    read_chk(5'd0, 64'd0, "R1 reset clears word");
    check("R1 reset clears code", 64'(rm_code), 64'd0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule